// File: doc/BRIEF.md
# Multithreaded Vector Register File

This block is the operand store of a barrel-threaded vector core. Every hardware thread owns a private set of 64 registers. Each register can be seen two ways: as a full vector of 32-bit lanes, or as a single 32-bit scalar held in lane 0. Integer and floating-point values share the same storage. Three source operands are read in every cycle from one thread. A fourth specifier, with its own thread number, writes results back. Writeback comes from a later pipeline stage, so its thread can differ from the read thread.

Vector writes are gated lane by lane. A 4-bit selector names one of fifteen mask registers. These mask registers are ordinary registers of the writing thread, so the same instructions that touch any other register also read and write them. A selector of zero opens every lane.

Top module: `vrf_mt`

## Requirements
- R1: While reset is asserted, all three read data outputs are zero.
- R2: Reads are synchronous with a latency of one clock. The storage index is {thread, register}. A write to one thread never changes the same register number of another thread.
- R3: The three read ports return their own registers in the same cycle, independently of each other.
- R4: A vector write (vec flag 1) with mask selector 0 writes every lane. A vector read returns all lanes, with lane i on bits [32i+31:32i].
- R5: A scalar write (vec flag 0) updates lane 0 only. The other lanes of that register keep their values.
- R6: A scalar read returns lane 0 in bits [31:0] and zero in every higher bit.
- R7: For a vector write with mask selector k from 1 to 15, the mask is bits [NLANES-1:0] of lane 0 of register 48+k of the writing thread. Lane i is written only when bit i of the mask is 1.
- R8: Mask registers 49 to 63 are read and written like any other register. A new mask value takes effect for the first write issued after the cycle that stored it.
- R9: When a read and a write target the same thread and register in the same cycle, the read returns the old value. The next read returns the new value.
- R10: With the write enable at 0, no register changes.
- R11: A scalar write ignores the mask selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the read outputs |
| rd_tid | input | $clog2(NTHREADS) | Thread whose registers are read |
| rd_reg | input | 3x6 | Register number for each read port |
| rd_vec | input | 3 | Per-port view: 1 = vector, 0 = scalar |
| rd_data | output | 3x(NLANES*32) | Registered read data for each port |
| wr_en | input | 1 | Write enable |
| wr_tid | input | $clog2(NTHREADS) | Thread being written |
| wr_reg | input | 6 | Register number being written |
| wr_vec | input | 1 | Write view: 1 = vector, 0 = scalar |
| wr_msel | input | 4 | Mask register selector; 0 opens all lanes |
| wr_data | input | NLANES*32 | Write data, lane i on bits [32i+31:32i] |

## Verification
A read and a write can fall in the same cycle. This matters most when both name the same thread and register, or when the write's mask register is also being read or was rewritten the cycle before. The stimulus table places a read of a register in the same step that writes it, so the old value must appear. The following step reads it again and must see the new value. Other rows rewrite a mask register and then issue a masked write on the next step. The bench keeps its own per-lane model, updated only after each step's reads are judged, so same-cycle collisions are scored against the value the register held before the edge.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int REG_AW    = 6;   // register number width
  localparam int MSEL_W    = 4;   // mask selector width
  localparam int NRD       = 3;   // read ports
  localparam int MASK_BASE = 48;  // selector k names register MASK_BASE + k

  // Register index of the mask picked by a non-zero selector.
  function automatic logic [REG_AW-1:0] mask_reg_of(input logic [MSEL_W-1:0] msel);
    return REG_AW'(MASK_BASE) + REG_AW'(msel);
  endfunction
endpackage

// File: rtl/vrf_lane_bank.sv
module vrf_lane_bank #(
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int NRD  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][DW-1:0]   rd_q,
  input  logic                     we,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_d,
  input  logic [AW-1:0]            peek_addr,
  output logic [DW-1:0]            peek_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Storage write; the read registers below sample the pre-edge contents.
  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      for (int p = 0; p < NRD; p++) rd_q[p] <= mem[rd_addr[p]];
    end
  end

  // Combinational look-up used by the write port to fetch a mask word.
  assign peek_q = mem[peek_addr];
endmodule

// File: rtl/vrf_wmask.sv
module vrf_wmask #(
  parameter int NLANES = 8,
  parameter int DW     = 32,
  parameter int MSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_vec,
  input  logic [MSEL_W-1:0] wr_msel,
  input  logic [DW-1:0]     mask_word,
  output logic [NLANES-1:0] lane_we
);
  // Lane gating: scalar touches lane 0 only; vector uses the mask unless
  // the selector is zero.
  function automatic logic [NLANES-1:0] gate(input logic en, input logic vec,
                                             input logic [MSEL_W-1:0] sel,
                                             input logic [DW-1:0] word);
    logic [NLANES-1:0] g;
    for (int i = 0; i < NLANES; i++) begin
      if (!en)            g[i] = 1'b0;
      else if (!vec)      g[i] = (i == 0);
      else if (sel == '0) g[i] = 1'b1;
      else                g[i] = word[i];
    end
    return g;
  endfunction

  assign lane_we = gate(wr_en, wr_vec, wr_msel, mask_word);

  logic unused_mask_hi;
  assign unused_mask_hi = ^mask_word;

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> lane_we == '0);
  p_scalar_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_vec) |-> lane_we == NLANES'(1));   // also R11
  p_open_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_vec && wr_msel == '0) |-> &lane_we);
endmodule

// File: rtl/vrf_mt.sv
module vrf_mt #(
  parameter int NTHREADS = 4,
  parameter int NLANES   = 8,
  parameter int DW       = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [$clog2(NTHREADS)-1:0]            rd_tid,
  input  logic [2:0][5:0]                        rd_reg,
  input  logic [2:0]                             rd_vec,
  output logic [2:0][NLANES*DW-1:0]              rd_data,
  input  logic                                   wr_en,
  input  logic [$clog2(NTHREADS)-1:0]            wr_tid,
  input  logic [5:0]                             wr_reg,
  input  logic                                   wr_vec,
  input  logic [3:0]                             wr_msel,
  input  logic [NLANES*DW-1:0]                   wr_data
);
  import vrf_pkg::*;

  localparam int TW = $clog2(NTHREADS);
  localparam int AW = TW + REG_AW;

  logic [NRD-1:0][AW-1:0]              rd_addr;
  logic [AW-1:0]                       wr_addr;
  logic [AW-1:0]                       mask_addr;
  logic [DW-1:0]                       mask_word;
  logic [NLANES-1:0]                   lane_we;
  logic [NLANES-1:0][NRD-1:0][DW-1:0]  bank_rd;
  logic [NRD-1:0]                      vec_q;

  always_comb begin
    for (int p = 0; p < NRD; p++) rd_addr[p] = {rd_tid, rd_reg[p]};
  end
  assign wr_addr   = {wr_tid, wr_reg};
  assign mask_addr = {wr_tid, mask_reg_of(wr_msel)};

  vrf_wmask #(.NLANES(NLANES), .DW(DW), .MSEL_W(MSEL_W)) u_wmask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_vec(wr_vec),
    .wr_msel(wr_msel), .mask_word(mask_word), .lane_we(lane_we)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    logic [DW-1:0] peek_w;
    vrf_lane_bank #(.AW(AW), .DW(DW), .NRD(NRD)) u_bank (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_q(bank_rd[l]),
      .we(lane_we[l]), .wr_addr(wr_addr), .wr_d(wr_data[l*DW +: DW]),
      .peek_addr(mask_addr), .peek_q(peek_w)
    );
    if (l == 0) begin : g_mask_src
      assign mask_word = peek_w;
    end else begin : g_no_mask
      logic unused_peek;
      assign unused_peek = ^peek_w;
    end
  end

  // View flag travels alongside the one-cycle read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= rd_vec;
  end

  always_comb begin
    for (int p = 0; p < NRD; p++)
      for (int l = 0; l < NLANES; l++)
        rd_data[p][l*DW +: DW] = (l == 0 || vec_q[p]) ? bank_rd[l][p] : '0;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_chk
    p_scalar_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_vec[p] |=> rd_data[p][NLANES*DW-1:DW] == '0);
  end

  p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_vec && wr_msel != '0) |-> (lane_we & ~mask_word[NLANES-1:0]) == '0);
endmodule

// File: tb/vrf_mt_bench.sv
module vrf_mt_bench;
  localparam int NT = 4;
  localparam int NL = 8;
  localparam int W  = NL * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rd_tid = '0;
  logic [2:0][5:0] rd_reg = '0;
  logic [2:0] rd_vec = '0;
  logic [2:0][W-1:0] rd_data;
  logic wr_en = 1'b0;
  logic [1:0] wr_tid = '0;
  logic [5:0] wr_reg = '0;
  logic wr_vec = 1'b0;
  logic [3:0] wr_msel = '0;
  logic [W-1:0] wr_data = '0;

  always #10 clk = ~clk;  // 50 MHz

  vrf_mt #(.NTHREADS(NT), .NLANES(NL), .DW(32)) u_vrf_mt (
    .clk(clk), .rst_n(rst_n), .rd_tid(rd_tid), .rd_reg(rd_reg), .rd_vec(rd_vec),
    .rd_data(rd_data), .wr_en(wr_en), .wr_tid(wr_tid), .wr_reg(wr_reg),
    .wr_vec(wr_vec), .wr_msel(wr_msel), .wr_data(wr_data)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] model [NT*64][NL];

  typedef struct packed {
    logic       wen;
    logic [1:0] wtid;
    logic [5:0] wreg;
    logic       wvec;
    logic [3:0] wmsel;
    logic [7:0] seed;
    logic [1:0] rtid;
    logic [5:0] r0, r1, r2;
    logic [2:0] rvec;
    logic [3:0] tag;
  } row_t;

  localparam int NROWS = 12;
  localparam row_t TBL [NROWS] = '{
    '{1'b1, 2'd0, 6'd1,  1'b1, 4'd0,  8'h01, 2'd0, 6'd1,  6'd2,  6'd3,  3'b111, 4'd4},
    '{1'b1, 2'd0, 6'd49, 1'b0, 4'd0,  8'h02, 2'd0, 6'd1,  6'd49, 6'd2,  3'b111, 4'd8},
    '{1'b1, 2'd0, 6'd7,  1'b1, 4'd1,  8'h5B, 2'd0, 6'd7,  6'd49, 6'd1,  3'b101, 4'd7},
    '{1'b1, 2'd1, 6'd7,  1'b1, 4'd0,  8'h04, 2'd0, 6'd7,  6'd7,  6'd7,  3'b110, 4'd2},
    '{1'b1, 2'd1, 6'd8,  1'b0, 4'd5,  8'h05, 2'd1, 6'd7,  6'd8,  6'd0,  3'b111, 4'd11},
    '{1'b0, 2'd0, 6'd0,  1'b0, 4'd0,  8'h00, 2'd1, 6'd8,  6'd8,  6'd8,  3'b010, 4'd5},
    '{1'b0, 2'd2, 6'd3,  1'b1, 4'd0,  8'h06, 2'd2, 6'd3,  6'd4,  6'd5,  3'b111, 4'd10},
    '{1'b1, 2'd3, 6'd63, 1'b1, 4'd0,  8'hC6, 2'd2, 6'd3,  6'd4,  6'd5,  3'b111, 4'd10},
    '{1'b1, 2'd3, 6'd10, 1'b1, 4'd15, 8'h08, 2'd3, 6'd63, 6'd10, 6'd10, 3'b100, 4'd7},
    '{1'b1, 2'd2, 6'd20, 1'b1, 4'd0,  8'h09, 2'd2, 6'd20, 6'd20, 6'd20, 3'b111, 4'd9},
    '{1'b0, 2'd0, 6'd0,  1'b0, 4'd0,  8'h00, 2'd2, 6'd20, 6'd21, 6'd22, 3'b001, 4'd3},
    '{1'b1, 2'd0, 6'd49, 1'b1, 4'd1,  8'hAA, 2'd3, 6'd10, 6'd10, 6'd10, 3'b111, 4'd8}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  // Lane i data: seed, lane number, inverted seed, and a low byte mixing both.
  function automatic logic [W-1:0] mk(input logic [7:0] s);
    logic [W-1:0] d;
    for (int i = 0; i < NL; i++)
      d[i*32 +: 32] = {s, 8'(i), ~s, s ^ 8'(i * 29)};
    return d;
  endfunction

  function automatic logic [W-1:0] expect_rd(input logic [1:0] t, input logic [5:0] r,
                                             input logic v);
    logic [W-1:0] e;
    for (int i = 0; i < NL; i++)
      e[i*32 +: 32] = (i == 0 || v) ? model[{t, r}][i] : 32'h0;
    return e;
  endfunction

  task automatic model_write(input logic en, input logic [1:0] t, input logic [5:0] r,
                             input logic v, input logic [3:0] ms, input logic [W-1:0] d);
    logic [31:0] mw;
    mw = model[{t, 6'(48 + ms)}][0];
    for (int i = 0; i < NL; i++)
      if (en && (v ? (ms == 0 || mw[i]) : (i == 0)))
        model[{t, r}][i] = d[i*32 +: 32];
  endtask

  // Drive at a falling edge, let one rising edge pass, judge at the next falling edge.
  task automatic step(input row_t s, input string tag, input bit judge);
    logic [2:0][W-1:0] exp_v;
    wr_en = s.wen; wr_tid = s.wtid; wr_reg = s.wreg; wr_vec = s.wvec;
    wr_msel = s.wmsel; wr_data = mk(s.seed);
    rd_tid = s.rtid; rd_reg = {s.r2, s.r1, s.r0}; rd_vec = s.rvec;
    exp_v[0] = expect_rd(s.rtid, s.r0, s.rvec[0]);
    exp_v[1] = expect_rd(s.rtid, s.r1, s.rvec[1]);
    exp_v[2] = expect_rd(s.rtid, s.r2, s.rvec[2]);
    @(negedge clk);
    if (judge) begin
      for (int p = 0; p < 3; p++) begin
        checks++;
        if (rd_data[p] !== exp_v[p]) begin
          errors++;
          $display("FAIL %s port %0d: actual %h expected %h", tag, p, rd_data[p], exp_v[p]);
        end
      end
    end
    model_write(s.wen, s.wtid, s.wreg, s.wvec, s.wmsel, mk(s.seed));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    row_t s;
    // R1: outputs held at zero during reset
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== '0) begin
      errors++;
      $display("FAIL R1: actual %h expected 0", rd_data);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Fill every register of every thread with a vector write through selector 0.
    for (int a = 0; a < NT * 64; a++) begin
      s = '{1'b1, 2'(a >> 6), 6'(a), 1'b1, 4'd0, 8'(a * 7 + 3), 2'd0, 6'd0, 6'd0, 6'd0, 3'b000, 4'd4};
      step(s, "R4", 1'b0);
    end

    for (int k = 0; k < NROWS; k++) step(TBL[k], tag_name(TBL[k].tag), 1'b1);

    // R6: scalar view of a full vector register, all ports
    s = '{1'b1, 2'd1, 6'd30, 1'b1, 4'd0, 8'h77, 2'd1, 6'd31, 6'd31, 6'd31, 3'b000, 4'd0};
    step(s, "R6", 1'b1);
    s = '{1'b0, 2'd0, 6'd0, 1'b0, 4'd0, 8'h00, 2'd1, 6'd30, 6'd30, 6'd30, 3'b000, 4'd0};
    step(s, "R6", 1'b1);

    // R9: collision on a mask register, then the new value
    s = '{1'b1, 2'd2, 6'd50, 1'b1, 4'd0, 8'h3C, 2'd2, 6'd50, 6'd50, 6'd50, 3'b111, 4'd0};
    step(s, "R9", 1'b1);
    s = '{1'b0, 2'd0, 6'd0, 1'b0, 4'd0, 8'h00, 2'd2, 6'd50, 6'd50, 6'd50, 3'b011, 4'd0};
    step(s, "R9", 1'b1);

    // R8: selector 2 now uses the mask just stored; check the masked write
    s = '{1'b1, 2'd2, 6'd11, 1'b1, 4'd2, 8'hE1, 2'd2, 6'd11, 6'd11, 6'd11, 3'b111, 4'd0};
    step(s, "R8", 1'b1);
    s = '{1'b0, 2'd0, 6'd0, 1'b0, 4'd0, 8'h00, 2'd2, 6'd11, 6'd50, 6'd12, 3'b111, 4'd0};
    step(s, "R8", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule